// File: doc/BRIEF.md
# Indirect Subbank Register File with Autoincrement

This block stores the configuration of a six-channel DMA controller in a bank of 31 sixteen-bit registers. The host does not see each register at its own address. It sees three windows: a pointer window, an incrementing data window and a fixed data window. The pointer selects one entry of the bank. A read or write through the incrementing window reaches the selected entry and moves the pointer on by one. A read or write through the fixed window reaches the same entry and leaves the pointer where it was.

The host port is a plain synchronous register port. A request is accepted in every cycle in which `host_req` is high; there is no back-pressure. Read data is combinational and valid in the cycle of the request. Every register update, including the pointer step, takes effect on the following rising clock edge. For this reason a burst of incrementing accesses in consecutive cycles walks through consecutive entries. On the output side every stored field is driven continuously to the transfer engine: five fields per channel plus one program-page word that all channels share.

Top module: `dma_subbank_regfile`

## Requirements
- R1: After reset every bank entry, every output field and the pointer are zero.
- R2: A write to the pointer window loads the pointer from `host_wdata[4:0]` and ignores the upper bits. A read of the pointer window returns the pointer zero-extended to 16 bits.
- R3: A read or write through the incrementing window reaches the entry selected by the pointer, and the pointer is one higher after the next clock edge. Back-to-back accesses therefore reach consecutive entries.
- R4: A read or write through the fixed window reaches the entry selected by the pointer and leaves the pointer unchanged.
- R5: Channel n (0 to 5) owns entries 5n to 5n+4, in this order: source address (+0), destination address (+1), element count (+2), sync/frame count (+3), mode control (+4). Each entry drives slot n of the matching output bus, at bits 16n+15 to 16n.
- R6: Entry 30 (1Eh) holds the shared program-page word and drives `page_out`.
- R7: When the pointer is 31 (1Fh), a data-window read returns zero and a data-window write changes no entry. The incrementing window still steps the pointer in this case.
- R8: The pointer is 5 bits wide and an increment from 31 wraps it to 0.
- R9: `host_rdata` is valid in the same cycle as the request. It is zero when `host_req` is low or when the address matches none of the three windows. A write to such an address changes nothing.
- R10: While `host_req` is low the pointer and all entries hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host access in this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, same cycle |
| ch_src | output | 96 | Source address field of each channel |
| ch_dst | output | 96 | Destination address field of each channel |
| ch_cnt | output | 96 | Element count field of each channel |
| ch_sync | output | 96 | Sync/frame count field of each channel |
| ch_mode | output | 96 | Mode control field of each channel |
| page_out | output | 16 | Shared program-page word |

## Verification
The bench builds the block with six channels and moves the three window addresses away from their defaults to 40h, 41h and 42h, so any address that is hard-wired instead of decoded from the parameters is caught. With six channels the bank ends at entry 30. This leaves exactly one unused pointer value, 31, so one incrementing burst covers every entry, the empty slot and the wrap back to zero. A behavioural model compares the read data and every output field on every cycle.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  // Default word width of one bank entry and host data path.
  localparam int unsigned DSB_DW = 16;

  // Per-channel field order; the position inside a channel block is behaviour.
  typedef enum logic [2:0] {
    FLD_SRC  = 3'd0,
    FLD_DST  = 3'd1,
    FLD_CNT  = 3'd2,
    FLD_SYNC = 3'd3,
    FLD_MODE = 3'd4
  } dsb_field_e;

  localparam int unsigned DSB_FIELDS = 5;

  // Which host window a request hits.
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_PTR  = 2'd1,
    WIN_INC  = 2'd2,
    WIN_FIX  = 2'd3
  } dsb_win_e;

endpackage

// File: rtl/dsb_window_decode.sv
module dsb_window_decode
  import dsb_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter logic [AW-1:0] ADDR_PTR = 8'h20,
  parameter logic [AW-1:0] ADDR_INC = 8'h21,
  parameter logic [AW-1:0] ADDR_FIX = 8'h22
) (
  input  logic          req,
  input  logic [AW-1:0] addr,
  output dsb_win_e      win
);

  always_comb begin
    win = WIN_NONE;
    if (req) begin
      if (addr == ADDR_PTR)      win = WIN_PTR;
      else if (addr == ADDR_INC) win = WIN_INC;
      else if (addr == ADDR_FIX) win = WIN_FIX;
    end
  end

endmodule

// File: rtl/dsb_pointer.sv
module dsb_pointer #(
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          step,
  output logic [PW-1:0] ptr
);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;

  // Load and step never coincide: they come from different windows.
  always_comb begin
    ptr_d = ptr_q;
    if (load)      ptr_d = load_val;
    else if (step) ptr_d = ptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // Step wraps modulo 2**PW (R8).
  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr_q == {PW{1'b1}}) |=> (ptr_q == '0));

endmodule

// File: rtl/dsb_entry_bank.sv
module dsb_entry_bank #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NENT = 31,
  parameter int unsigned PW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [PW-1:0]      idx,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [NENT*DW-1:0] flat
);

  localparam int unsigned SLOTS = 2 ** PW;

  logic [DW-1:0] ent [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NENT) begin : g_real
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     q <= '0;
        else if (we && idx == PW'(i))   q <= wdata;
      end
      assign ent[i] = q;
      assign flat[i*DW +: DW] = q;
    end else begin : g_empty
      // Unused subaddress: reads as zero, no storage.
      assign ent[i] = '0;
    end
  end

  assign rdata = ent[idx];

  // A write to a real entry lands on the next edge (R3, R4).
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && 32'(idx) < NENT) |=> (ent[$past(idx)] == $past(wdata)));

  // An unused slot reads zero even right after a write to it (R7).
  assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && 32'(idx) >= NENT) |=> (ent[$past(idx)] == '0));

endmodule

// File: rtl/dma_subbank_regfile.sv
module dma_subbank_regfile
  import dsb_pkg::*;
#(
  parameter int unsigned NCH      = 6,
  parameter int unsigned DW       = DSB_DW,
  parameter int unsigned AW       = 8,
  parameter logic [AW-1:0] ADDR_PTR = 8'h20,
  parameter logic [AW-1:0] ADDR_INC = 8'h21,
  parameter logic [AW-1:0] ADDR_FIX = 8'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [AW-1:0]     host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic [NCH*DW-1:0] ch_src,
  output logic [NCH*DW-1:0] ch_dst,
  output logic [NCH*DW-1:0] ch_cnt,
  output logic [NCH*DW-1:0] ch_sync,
  output logic [NCH*DW-1:0] ch_mode,
  output logic [DW-1:0]     page_out
);

  localparam int unsigned NENT     = NCH * DSB_FIELDS + 1;
  localparam int unsigned PAGE_IDX = NCH * DSB_FIELDS;
  localparam int unsigned PW       = $clog2(NENT);

  dsb_win_e          win;
  logic [PW-1:0]     ptr;
  logic [DW-1:0]     bank_rdata;
  logic [NENT*DW-1:0] bank_flat;
  logic              data_win;

  dsb_window_decode #(
    .AW(AW), .ADDR_PTR(ADDR_PTR), .ADDR_INC(ADDR_INC), .ADDR_FIX(ADDR_FIX)
  ) u_decode (
    .req (host_req),
    .addr(host_addr),
    .win (win)
  );

  assign data_win = (win == WIN_INC) || (win == WIN_FIX);

  dsb_pointer #(.PW(PW)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    ((win == WIN_PTR) && host_wr),
    .load_val(host_wdata[PW-1:0]),
    .step    (win == WIN_INC),
    .ptr     (ptr)
  );

  dsb_entry_bank #(.DW(DW), .NENT(NENT), .PW(PW)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (data_win && host_wr),
    .idx  (ptr),
    .wdata(host_wdata),
    .rdata(bank_rdata),
    .flat (bank_flat)
  );

  always_comb begin
    unique case (win)
      WIN_PTR:          host_rdata = {{(DW-PW){1'b0}}, ptr};
      WIN_INC, WIN_FIX: host_rdata = bank_rdata;
      default:          host_rdata = '0;
    endcase
  end

  // Channel n owns entries FIELDS*n .. FIELDS*n+4.
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int unsigned BASE = n * DSB_FIELDS;
    assign ch_src [n*DW +: DW] = bank_flat[(BASE + FLD_SRC ) * DW +: DW];
    assign ch_dst [n*DW +: DW] = bank_flat[(BASE + FLD_DST ) * DW +: DW];
    assign ch_cnt [n*DW +: DW] = bank_flat[(BASE + FLD_CNT ) * DW +: DW];
    assign ch_sync[n*DW +: DW] = bank_flat[(BASE + FLD_SYNC) * DW +: DW];
    assign ch_mode[n*DW +: DW] = bank_flat[(BASE + FLD_MODE) * DW +: DW];
  end

  assign page_out = bank_flat[PAGE_IDX*DW +: DW];

  // Pointer window write loads low bits (R2).
  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_wr && host_addr == ADDR_PTR) |=> (ptr == $past(host_wdata[PW-1:0])));

  // Incrementing window steps the pointer (R3).
  assert_inc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_addr == ADDR_INC) |=> (ptr == PW'($past(ptr) + 1'b1)));

  // Fixed window keeps the pointer (R4).
  assert_fix_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_addr == ADDR_FIX) |=> $stable(ptr));

  // Empty slot reads zero (R7).
  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && (host_addr == ADDR_INC || host_addr == ADDR_FIX) && 32'(ptr) >= NENT)
      |-> (host_rdata == '0));

  // Idle cycles hold all state (R10).
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req |=> ($stable(ptr) && $stable(bank_flat)));

  // No request means zero read data (R9).
  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req |-> (host_rdata == '0));

endmodule

// File: tb/dma_subbank_regfile_tb.sv
module dma_subbank_regfile_tb;

  localparam int NCH = 6;
  localparam int DW  = 16;
  localparam logic [7:0] A_PTR = 8'h40;
  localparam logic [7:0] A_INC = 8'h41;
  localparam logic [7:0] A_FIX = 8'h42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0;
  logic host_wr = 1'b0;
  logic [7:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic [NCH*DW-1:0] ch_src, ch_dst, ch_cnt, ch_sync, ch_mode;
  logic [DW-1:0] page_out;

  always #5 clk = ~clk;

  dma_subbank_regfile #(
    .NCH(NCH), .DW(DW), .AW(8),
    .ADDR_PTR(A_PTR), .ADDR_INC(A_INC), .ADDR_FIX(A_FIX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ch_src(ch_src), .ch_dst(ch_dst), .ch_cnt(ch_cnt), .ch_sync(ch_sync),
    .ch_mode(ch_mode), .page_out(page_out)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mdl [32];
  int mptr = 0;

  task automatic check16(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Compare all output fields against the model: layout per R5/R6.
  task automatic check_outputs(input string tag);
    int bad = 0;
    logic [DW-1:0] a = '0, e = '0;
    for (int n = 0; n < NCH; n++) begin
      logic [DW-1:0] got [5];
      got[0] = ch_src[n*DW +: DW];  got[1] = ch_dst[n*DW +: DW];
      got[2] = ch_cnt[n*DW +: DW];  got[3] = ch_sync[n*DW +: DW];
      got[4] = ch_mode[n*DW +: DW];
      for (int f = 0; f < 5; f++)
        if (got[f] !== mdl[5*n+f] && bad == 0) begin bad = 1; a = got[f]; e = mdl[5*n+f]; end
    end
    if (page_out !== mdl[30] && bad == 0) begin bad = 1; a = page_out; e = mdl[30]; end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s (R5/R6 outputs): actual %h expected %h", tag, a, e);
    end
  endtask

  task automatic step(input bit rq, input bit w, input logic [7:0] a,
                      input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] exp;
    @(negedge clk);
    host_req = rq; host_wr = w; host_addr = a; host_wdata = d;
    #1;
    if (!rq)                       exp = '0;
    else if (a == A_PTR)           exp = DW'(mptr);
    else if (a == A_INC || a == A_FIX) exp = (mptr < 31) ? mdl[mptr] : '0;
    else                           exp = '0;
    check16({tag, " rdata"}, host_rdata, exp);
    check_outputs(tag);
    if (rq) begin
      if (a == A_PTR && w) mptr = int'(d[4:0]);
      else if ((a == A_INC || a == A_FIX) && w && mptr < 31) mdl[mptr] = d;
      if (a == A_INC) mptr = (mptr + 1) % 32;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    check_outputs("R1 during reset");
    rst_n = 1'b1;
    // R1: pointer reads zero after reset
    step(1, 0, A_PTR, 16'h0, "R1 ptr after reset");
    step(1, 0, A_INC, 16'h0, "R1 entry0 after reset");
    step(1, 1, A_PTR, 16'h0, "R2 clear ptr");
    // R3/R5/R6/R7/R8: burst write across whole bank, empty slot and wrap
    for (int i = 0; i < 32; i++)
      step(1, 1, A_INC, 16'hA000 + 16'(i * 16'h0111), "R3 burst write");
    step(1, 0, A_PTR, 16'h0, "R8 ptr wrapped");
    // R3/R7: burst read back, slot 31 reads zero
    for (int i = 0; i < 32; i++)
      step(1, 0, A_INC, 16'h0, "R3 R7 burst read");
    // R4: fixed window keeps pointer
    step(1, 1, A_PTR, 16'h0007, "R2 load 7");
    step(1, 1, A_FIX, 16'h1234, "R4 fixed write");
    step(1, 1, A_FIX, 16'h5678, "R4 fixed rewrite");
    step(1, 0, A_FIX, 16'h0, "R4 fixed read");
    step(1, 0, A_PTR, 16'h0, "R4 ptr unchanged");
    // R6: page word through fixed window
    step(1, 1, A_PTR, 16'h001E, "R6 point page");
    step(1, 1, A_FIX, 16'hBEEF, "R6 page write");
    // R7: fixed write to empty slot
    step(1, 1, A_PTR, 16'h001F, "R7 point empty");
    step(1, 1, A_FIX, 16'hFFFF, "R7 empty write");
    step(1, 0, A_FIX, 16'h0, "R7 empty read");
    step(1, 1, A_INC, 16'hFFFF, "R7 empty inc write");
    step(1, 0, A_PTR, 16'h0, "R8 wrap after empty");
    // R2: upper bits ignored
    step(1, 1, A_PTR, 16'hFFE3, "R2 masked load");
    step(1, 0, A_PTR, 16'h0, "R2 readback");
    // R9: unmapped address
    step(1, 1, 8'h43, 16'hDEAD, "R9 unmapped write");
    step(1, 0, 8'h00, 16'h0, "R9 unmapped read");
    step(1, 0, A_FIX, 16'h0, "R9 entry untouched");
    // R10: idle with garbage on the bus
    step(0, 1, A_INC, 16'hCAFE, "R10 idle inc");
    step(0, 1, A_PTR, 16'h0011, "R10 idle ptr");
    step(1, 0, A_PTR, 16'h0, "R10 ptr held");
    step(1, 0, A_FIX, 16'h0, "R10 entry held");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule